// File: doc/BRIEF.md
# LCD panel power sequencer

This controller brings a flat-panel display link up and tears it down in a fixed order. It drives five controls: the panel supply enable, the serializer power-down line (active low), the video-source enable, a black-data select and the backlight enable. Power-up turns on the panel supply and waits for it to settle. It then releases the serializer and starts the video source on forced black data. Black data is held long enough for the serializer clock to lock, then real pixels are switched in, and the backlight comes on last. Power-down reverses the order. The backlight goes off first and a programmable delay follows. Then black data is shown for a counted number of frames, the serializer goes back into power-down, the video source stops, and the panel supply drops.

Delays are counted from an external 1 ms tick pulse. The black dwell is counted from frame-start strobes. All lengths are parameters: `SETTLE_MS`, `LOCK_MS`, `BLOFF_MS` and `DWELL_FRAMES`. When `black_sel` is 1, the downstream mux selects black pixels. When it is 0, real image data passes. `busy` is high in every transition state, and `ready` is high only when the link is fully on.

States:
- OFF
- SETTLE: panel supply on, waiting.
- SER_ON: serializer released.
- LOCK: video on, black, waiting for lock.
- IMAGE: real pixels, backlight still off.
- ON
- BL_OFF: backlight off, waiting.
- DWELL: black frames.
- SER_DOWN
- VID_OFF

Transitions:
- OFF to SETTLE on `on_req`.
- SETTLE to SER_ON after `SETTLE_MS` ticks.
- SER_ON to LOCK after one clock.
- LOCK to IMAGE after `LOCK_MS+1` ticks.
- IMAGE to ON after one clock.
- ON to BL_OFF on `off_req`.
- BL_OFF to DWELL after `BLOFF_MS` ticks.
- DWELL to SER_DOWN after `DWELL_FRAMES` strobes.
- SER_DOWN to VID_OFF to OFF, one clock each.
- Abort paths: SETTLE to OFF, SER_ON to VID_OFF, and LOCK or IMAGE to DWELL.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset the outputs are as follows: `panel_pwr_en`, `ser_pd_n`, `video_en`, `backlight_en`, `busy` and `ready` are 0, and `black_sel` is 1.
- R2: In OFF, a one-clock `on_req` moves the block to SETTLE on the next clock edge. SETTLE has `panel_pwr_en`=1, `busy`=1, `black_sel`=1, and `ser_pd_n`, `video_en`, `backlight_en` and `ready` at 0.
- R3: SETTLE lasts until `SETTLE_MS` `ms_tick` pulses have been seen, and leaves one clock after the last one (at once when `SETTLE_MS`=0). It goes to SER_ON, which raises `ser_pd_n` with `video_en` still 0 and lasts one clock.
- R4: LOCK sets `video_en`=1 and `black_sel`=1, and holds until `LOCK_MS+1` ticks have been seen. The state changes one clock after the last tick.
- R5: IMAGE (`black_sel`=0, `backlight_en`=0) lasts one clock. It is followed by ON, where `backlight_en`=1, `ready`=1 and `busy`=0.
- R6: In ON, `off_req` moves the block to BL_OFF, where `backlight_en`=0 and `black_sel` is still 0. BL_OFF leaves one clock after `BLOFF_MS` ticks.
- R7: DWELL sets `black_sel`=1 and lasts until `DWELL_FRAMES` `frame_start` strobes have arrived inside DWELL; strobes seen outside DWELL do not count.
- R8: After DWELL, SER_DOWN drops `ser_pd_n` while `video_en` stays 1. VID_OFF then drops `video_en` while the panel supply stays on. OFF follows, each step lasting one clock.
- R9: An `off_req` during SETTLE lets the settle delay finish and then returns to OFF. An `off_req` during SER_ON goes straight to VID_OFF.
- R10: An `off_req` during LOCK lets the lock wait finish and then enters DWELL. An `off_req` during IMAGE enters DWELL directly. Either way the rest of power-down follows.
- R11: `on_req` outside OFF has no effect, and neither does `off_req` in OFF. The outputs stay the same, and a power-down still ends in OFF.
- R12: `busy` is 1 exactly in the transition states, `ready` is 1 only in ON, and the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Power-up request pulse |
| off_req | input | 1 | Power-down request pulse |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| frame_start | input | 1 | One-clock pulse at each frame start |
| panel_pwr_en | output | 1 | Panel supply enable |
| ser_pd_n | output | 1 | Serializer power-down, low = powered down |
| video_en | output | 1 | Video source enable |
| black_sel | output | 1 | 1 = force black pixels, 0 = real image |
| backlight_en | output | 1 | Backlight enable |
| busy | output | 1 | Sequencer in a transition state |
| ready | output | 1 | Link fully on |

## Verification
The hardest cases to reach are power-off requests that land inside the single-clock steps SER_ON and IMAGE. There, the request must coincide with the one clock edge on which the state leaves. The bench starts a power-up and advances it tick by tick and clock by clock to each power-up state in turn. It raises `off_req` on the falling edge while that state is present, then follows the abort path to OFF and compares every output on every step. The same sweep covers the states that wait on the tick and the abort paths from SETTLE and LOCK.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_SETTLE,
        ST_SER_ON,
        ST_LOCK,
        ST_IMAGE,
        ST_ON,
        ST_BL_OFF,
        ST_DWELL,
        ST_SER_DOWN,
        ST_VID_OFF
    } seq_state_t;

    typedef struct packed {
        logic panel_pwr_en;
        logic ser_pd_n;
        logic video_en;
        logic black_sel;
        logic backlight_en;
        logic busy;
        logic ready;
    } seq_out_t;

    // States in which an abort request must be held until the step ends
    function automatic logic is_rising(seq_state_t s);
        return (s == ST_SETTLE) || (s == ST_SER_ON) ||
               (s == ST_LOCK)   || (s == ST_IMAGE);
    endfunction

endpackage

// File: rtl/seq_event_counter.sv
module seq_event_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         evt,
    input  logic [W-1:0] target,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (evt && (cnt_q != {W{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q >= target);

endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
    import panel_seq_pkg::*;
(
    input  seq_state_t st,
    output seq_out_t   o
);
    always_comb begin
        o = '0;
        o.black_sel = 1'b1;
        o.busy      = 1'b1;
        unique case (st)
            ST_OFF: begin
                o.busy = 1'b0;
            end
            ST_SETTLE: begin
                o.panel_pwr_en = 1'b1;
            end
            ST_SER_ON: begin
                o.panel_pwr_en = 1'b1;
                o.ser_pd_n     = 1'b1;
            end
            ST_LOCK: begin
                o.panel_pwr_en = 1'b1;
                o.ser_pd_n     = 1'b1;
                o.video_en     = 1'b1;
            end
            ST_IMAGE: begin
                o.panel_pwr_en = 1'b1;
                o.ser_pd_n     = 1'b1;
                o.video_en     = 1'b1;
                o.black_sel    = 1'b0;
            end
            ST_ON: begin
                o.panel_pwr_en = 1'b1;
                o.ser_pd_n     = 1'b1;
                o.video_en     = 1'b1;
                o.black_sel    = 1'b0;
                o.backlight_en = 1'b1;
                o.busy         = 1'b0;
                o.ready        = 1'b1;
            end
            ST_BL_OFF: begin
                o.panel_pwr_en = 1'b1;
                o.ser_pd_n     = 1'b1;
                o.video_en     = 1'b1;
                o.black_sel    = 1'b0;
            end
            ST_DWELL: begin
                o.panel_pwr_en = 1'b1;
                o.ser_pd_n     = 1'b1;
                o.video_en     = 1'b1;
            end
            ST_SER_DOWN: begin
                o.panel_pwr_en = 1'b1;
                o.video_en     = 1'b1;
            end
            ST_VID_OFF: begin
                o.panel_pwr_en = 1'b1;
            end
            default: begin
                o.busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import panel_seq_pkg::*;
#(
    parameter int SETTLE_MS    = 20,
    parameter int LOCK_MS      = 1,
    parameter int BLOFF_MS     = 10,
    parameter int DWELL_FRAMES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic off_req,
    input  logic ms_tick,
    input  logic frame_start,
    output logic panel_pwr_en,
    output logic ser_pd_n,
    output logic video_en,
    output logic black_sel,
    output logic backlight_en,
    output logic busy,
    output logic ready
);
    localparam int LOCK_TICKS = LOCK_MS + 1;
    localparam int MS_A       = (SETTLE_MS > BLOFF_MS) ? SETTLE_MS : BLOFF_MS;
    localparam int MS_MAX     = (MS_A > LOCK_TICKS) ? MS_A : LOCK_TICKS;
    localparam int MS_W       = $clog2(MS_MAX + 2);
    localparam int FR_W       = $clog2(DWELL_FRAMES + 2);

    seq_state_t state_q, state_n;
    logic       off_pend_q;
    logic       off_any;
    logic       step_clr;
    logic       ms_done, fr_done;
    logic [MS_W-1:0] ms_target;
    seq_out_t   outs;

    assign off_any  = off_req | off_pend_q;
    assign step_clr = (state_n != state_q);

    always_comb begin
        unique case (state_q)
            ST_SETTLE: ms_target = MS_W'(SETTLE_MS);
            ST_LOCK:   ms_target = MS_W'(LOCK_TICKS);
            ST_BL_OFF: ms_target = MS_W'(BLOFF_MS);
            default:   ms_target = '0;
        endcase
    end

    seq_event_counter #(.W(MS_W)) u_ms_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (step_clr),
        .evt    (ms_tick),
        .target (ms_target),
        .done   (ms_done)
    );

    seq_event_counter #(.W(FR_W)) u_frame_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (step_clr),
        .evt    (frame_start),
        .target (FR_W'(DWELL_FRAMES)),
        .done   (fr_done)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF:      if (on_req) state_n = ST_SETTLE;
            ST_SETTLE:   if (ms_done) state_n = off_any ? ST_OFF : ST_SER_ON;
            ST_SER_ON:   state_n = off_any ? ST_VID_OFF : ST_LOCK;
            ST_LOCK:     if (ms_done) state_n = off_any ? ST_DWELL : ST_IMAGE;
            ST_IMAGE:    state_n = off_any ? ST_DWELL : ST_ON;
            ST_ON:       if (off_req) state_n = ST_BL_OFF;
            ST_BL_OFF:   if (ms_done) state_n = ST_DWELL;
            ST_DWELL:    if (fr_done) state_n = ST_SER_DOWN;
            ST_SER_DOWN: state_n = ST_VID_OFF;
            ST_VID_OFF:  state_n = ST_OFF;
            default:     state_n = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            off_pend_q <= 1'b0;
        end else begin
            state_q    <= state_n;
            off_pend_q <= is_rising(state_q) && is_rising(state_n) &&
                          (off_pend_q || off_req);
        end
    end

    seq_out_decode u_dec (
        .st (state_q),
        .o  (outs)
    );

    assign panel_pwr_en = outs.panel_pwr_en;
    assign ser_pd_n     = outs.ser_pd_n;
    assign video_en     = outs.video_en;
    assign black_sel    = outs.black_sel;
    assign backlight_en = outs.backlight_en;
    assign busy         = outs.busy;
    assign ready        = outs.ready;

endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk #(
    parameter int DWELL_FRAMES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic panel_pwr_en,
    input logic ser_pd_n,
    input logic video_en,
    input logic black_sel,
    input logic backlight_en,
    input logic busy,
    input logic ready
);
    localparam int FR_W = $clog2(DWELL_FRAMES + 2);

    logic [FR_W-1:0] black_frames_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            black_frames_q <= '0;
        end else if (!(video_en && black_sel)) begin
            black_frames_q <= '0;
        end else if (frame_start && (black_frames_q != {FR_W{1'b1}})) begin
            black_frames_q <= black_frames_q + 1'b1;
        end
    end

    assert_release_after_panel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_pd_n) |-> ($past(panel_pwr_en) && !video_en));

    assert_video_after_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(video_en) |-> ($past(ser_pd_n) && black_sel));

    assert_backlight_needs_image_R5: assert property (@(posedge clk) disable iff (!rst_n)
        backlight_en |-> (panel_pwr_en && ser_pd_n && video_en && !black_sel));

    assert_backlight_after_image_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(backlight_en) |-> $past(video_en && !black_sel && !backlight_en));

    assert_dark_before_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_pd_n) |-> $past(!backlight_en));

    assert_dwell_frames_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ser_pd_n) && video_en) |-> (black_frames_q >= FR_W'(DWELL_FRAMES)));

    assert_pd_before_video_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(video_en) |-> $past(!ser_pd_n));

    assert_panel_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_pwr_en) |-> $past(!video_en && !ser_pd_n));

    assert_busy_ready_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready));

    assert_ready_fully_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> backlight_en);

endmodule

bind panel_pwr_seq panel_pwr_seq_chk #(.DWELL_FRAMES(DWELL_FRAMES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .panel_pwr_en (panel_pwr_en),
    .ser_pd_n     (ser_pd_n),
    .video_en     (video_en),
    .black_sel    (black_sel),
    .backlight_en (backlight_en),
    .busy         (busy),
    .ready        (ready)
);

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;
    localparam int SETTLE = 2;
    localparam int LOCK   = 1;
    localparam int BLOFF  = 1;
    localparam int FRAMES = 3;

    localparam int P_OFF = 0, P_SETTLE = 1, P_SERON = 2, P_LOCK = 3, P_IMAGE = 4,
                   P_ON = 5, P_BLOFF = 6, P_DWELL = 7, P_SERDN = 8, P_VIDOFF = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_req = 1'b0, off_req = 1'b0, ms_tick = 1'b0, frame_start = 1'b0;
    logic panel_pwr_en, ser_pd_n, video_en, black_sel, backlight_en, busy, ready;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    panel_pwr_seq #(
        .SETTLE_MS(SETTLE), .LOCK_MS(LOCK), .BLOFF_MS(BLOFF), .DWELL_FRAMES(FRAMES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
        .ms_tick(ms_tick), .frame_start(frame_start),
        .panel_pwr_en(panel_pwr_en), .ser_pd_n(ser_pd_n), .video_en(video_en),
        .black_sel(black_sel), .backlight_en(backlight_en), .busy(busy), .ready(ready)
    );

    // {panel, pd_n, video, black, backlight, busy, ready}
    function automatic logic [6:0] exp_vec(int ph);
        case (ph)
            P_OFF:    return 7'b0001000;
            P_SETTLE: return 7'b1001010;
            P_SERON:  return 7'b1101010;
            P_LOCK:   return 7'b1111010;
            P_IMAGE:  return 7'b1110010;
            P_ON:     return 7'b1110101;
            P_BLOFF:  return 7'b1110010;
            P_DWELL:  return 7'b1111010;
            P_SERDN:  return 7'b1011010;
            P_VIDOFF: return 7'b1001010;
            default:  return 7'b0000000;
        endcase
    endfunction

    task automatic check(int ph, string tag);
        logic [6:0] act;
        act = {panel_pwr_en, ser_pd_n, video_en, black_sel, backlight_en, busy, ready};
        n_checks++;
        if (act !== exp_vec(ph)) begin
            n_fail++;
            $display("FAIL %s: phase %0d actual %b expected %b", tag, ph, act, exp_vec(ph));
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_on();    on_req = 1'b1;      step(); on_req = 1'b0;      endtask
    task automatic pulse_off();   off_req = 1'b1;     step(); off_req = 1'b0;     endtask
    task automatic pulse_tick();  ms_tick = 1'b1;     step(); ms_tick = 1'b0;     endtask
    task automatic pulse_frame(); frame_start = 1'b1; step(); frame_start = 1'b0; endtask

    // Run power-up from OFF until the given phase has just been entered
    task automatic run_up(int stop_at);
        pulse_on();
        check(P_SETTLE, "R2 enter settle");
        if (stop_at == P_SETTLE) return;
        for (int i = 0; i < SETTLE; i++) begin
            pulse_tick();
            check(P_SETTLE, "R3 settle counting");
        end
        step();
        check(P_SERON, "R3 serializer release");
        if (stop_at == P_SERON) return;
        step();
        check(P_LOCK, "R4 black lock dwell");
        if (stop_at == P_LOCK) return;
        for (int i = 0; i < LOCK + 1; i++) begin
            pulse_tick();
            check(P_LOCK, "R4 lock counting");
        end
        step();
        check(P_IMAGE, "R5 true image");
        if (stop_at == P_IMAGE) return;
        step();
        check(P_ON, "R5 fully on");
    endtask

    task automatic run_tail_from_dwell(string tag);
        for (int i = 0; i < FRAMES; i++) begin
            check(P_DWELL, tag);
            pulse_frame();
        end
        check(P_DWELL, "R7 last strobe counted");
        step();
        check(P_SERDN, "R8 serializer down");
        step();
        check(P_VIDOFF, "R8 video off");
        step();
        check(P_OFF, "R8 panel off");
    endtask

    initial begin
        @(negedge clk);
        check(P_OFF, "R1 in reset");
        repeat (3) step();
        check(P_OFF, "R1 reset state");
        rst_n = 1'b1;
        step();
        check(P_OFF, "R1 after release");

        pulse_off();
        step();
        check(P_OFF, "R11 off_req in OFF ignored");

        // Full up and down, with ignored stimulus along the way
        run_up(P_ON);
        pulse_on();
        step();
        check(P_ON, "R11 on_req in ON ignored");
        for (int i = 0; i < FRAMES; i++) pulse_frame();
        check(P_ON, "R7 strobes in ON");
        pulse_tick();
        check(P_ON, "R12 ticks in ON");
        pulse_off();
        check(P_BLOFF, "R6 backlight off");
        for (int i = 0; i < BLOFF; i++) begin
            pulse_tick();
            check(P_BLOFF, "R6 bl-off delay");
        end
        step();
        check(P_DWELL, "R7 enter dwell");
        pulse_frame();
        pulse_on();
        check(P_DWELL, "R11 on_req in dwell ignored");
        for (int i = 1; i < FRAMES; i++) begin
            check(P_DWELL, "R7 dwell counting");
            pulse_frame();
        end
        step();
        check(P_SERDN, "R8 serializer down");
        step();
        check(P_VIDOFF, "R8 video off");
        step();
        check(P_OFF, "R8 panel off");
        repeat (2) step();
        check(P_OFF, "R11 stays off after on_req in dwell");

        // Sweep of abort injection points during power-up
        for (int inj = P_SETTLE; inj <= P_IMAGE; inj++) begin
            run_up(inj);
            pulse_off();
            case (inj)
                P_SETTLE: begin
                    check(P_SETTLE, "R9 settle completes");
                    for (int i = 0; i < SETTLE; i++) pulse_tick();
                    check(P_SETTLE, "R9 settle last tick");
                    step();
                    check(P_OFF, "R9 abort settle to off");
                end
                P_SERON: begin
                    check(P_VIDOFF, "R9 abort ser_on to vid_off");
                    step();
                    check(P_OFF, "R9 abort ser_on to off");
                end
                P_LOCK: begin
                    check(P_LOCK, "R10 lock completes");
                    for (int i = 0; i < LOCK + 1; i++) pulse_tick();
                    check(P_LOCK, "R10 lock last tick");
                    step();
                    run_tail_from_dwell("R10 abort lock dwell");
                end
                default: begin
                    run_tail_from_dwell("R10 abort image dwell");
                end
            endcase
            step();
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog expired: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule